// File: doc/BRIEF.md
# Pattern-Scaled Saturating Scalar Decrement

This block reduces a signed scalar by an amount it works out for itself. A 5-bit pattern code is decoded against the number of 64-bit lanes in the configured vector length. The code can ask for a fixed count, the largest power of two, the largest multiple of three or of four, or every lane. The resulting count is scaled by a multiplier from 1 to 16 and subtracted from the scalar. The difference is clamped to the signed range of the selected width, either 32 or 64 bits. A clamped 32-bit result is widened to 64 bits by sign extension.

The unit sits in an execution pipeline as one registered stage. Each cycle in which `in_valid` is high produces a result, and `out_valid` marks that result exactly one clock later. There is no backpressure. The configured vector length must be a multiple of 128 from 128 to 2048, which gives 2 to 32 lanes.

Top module: `pred_satdec`

## Requirements
- R1: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high, and each such cycle carries the result of that input.
- R2: The multiplier applied to the element count is `in_mult` + 1, so it runs from 1 (field 0) to 16 (field 15). The result equals the signed operand minus count × multiplier whenever that difference fits the selected range.
- R3: Pattern 5'b00000 gives the largest power of two that is not above the lane count. The lane count is `cfg_vlen` / 64.
- R4: Patterns 5'b00001 to 5'b01000 give counts 1 to 8. Patterns 5'b01001 to 5'b01101 give 16, 32, 64, 128 and 256. A fixed count above the lane count gives 0; it is not clamped to the lane count.
- R5: Pattern 5'b11101 gives the largest multiple of 4 not above the lane count. Pattern 5'b11110 gives the largest multiple of 3. Pattern 5'b11111 gives the lane count itself.
- R6: Every other pattern code gives a count of 0. The operand then passes through unchanged, with `out_sat` low.
- R7: With `in_narrow` low, a difference below -2^63 yields 64'h8000_0000_0000_0000 with `out_sat` high. A difference of exactly -2^63 is not saturated.
- R8: With `in_narrow` high, only `in_operand[31:0]` is used, as a signed value. The 32-bit result is sign-extended to 64 bits. A difference below -2^31 yields 64'hFFFF_FFFF_8000_0000 with `out_sat` high.
- R9: `out_sat` is low whenever the exact difference lies within the selected signed range.
- R10: A synchronous reset (`rst` high) clears `out_valid`, `out_result` and `out_sat` in the next cycle, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation present this cycle |
| in_pattern | input | 5 | Element-count pattern code |
| in_mult | input | 4 | Multiplier field; multiplier is field + 1 |
| in_narrow | input | 1 | 1: 32-bit signed range, 0: 64-bit signed range |
| in_operand | input | 64 | Scalar to decrement |
| cfg_vlen | input | 12 | Vector length in bits, multiple of 128 from 128 to 2048 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Saturated difference, sign-extended in 32-bit mode |
| out_sat | output | 1 | Difference fell below the selected minimum |

## Verification
The hardest region to reach from the ports is the saturation edge. There the operand lies within 512 of the signed minimum, and the largest possible subtrahend decides whether the result clamps. The bench places operands at exactly the minimum plus count × multiplier, and one below it, in both widths. Counts come from the all-lanes pattern at 32 lanes, with the multiplier field at its top value.

Fixed counts larger than the lane count, which must collapse to zero, are reached by sweeping small vector lengths against the large fixed codes. A long stretch of mixed codes, lengths and operands follows, with operands biased toward the minimum. It is compared against a behavioural model on every clock.

// File: rtl/psd_pkg.sv
package psd_pkg;

   localparam int PAT_W = 5;

   // pattern codes whose value the decoder depends on
   localparam logic [PAT_W-1:0] PAT_POW2     = 5'b00000;
   localparam logic [PAT_W-1:0] PAT_FIX_LO   = 5'b00001;
   localparam logic [PAT_W-1:0] PAT_FIX_HI   = 5'b01000;
   localparam logic [PAT_W-1:0] PAT_BIG_LO   = 5'b01001;
   localparam int               BIG_STEPS    = 5;   // 16,32,64,128,256
   localparam int               BIG_BASE     = 16;
   localparam logic [PAT_W-1:0] PAT_MUL4     = 5'b11101;
   localparam logic [PAT_W-1:0] PAT_MUL3     = 5'b11110;
   localparam logic [PAT_W-1:0] PAT_ALL      = 5'b11111;

endpackage

// File: rtl/psd_count_decode.sv
module psd_count_decode
   import psd_pkg::*;
#(
   parameter int LANE_W = 6
)(
   input  logic [PAT_W-1:0]  pattern,
   input  logic [LANE_W-1:0] lanes,
   output logic [LANE_W-1:0] count
);

   logic [LANE_W-1:0] pow2_val;
   logic [LANE_W-1:0] mul4_val;
   logic [LANE_W-1:0] mul3_val;
   logic [LANE_W-1:0] mod3_val;
   logic [LANE_W-1:0] small_val;
   logic [LANE_W-1:0] big_val;
   logic [LANE_W-1:0] big_part [BIG_STEPS];

   // highest set bit of the lane count
   always_comb begin
      pow2_val = '0;
      for (int i = 0; i < LANE_W; i++) begin
         if (lanes[i]) pow2_val = LANE_W'(1) << i;
      end
   end

   assign mul4_val = {lanes[LANE_W-1:2], 2'b00};
   assign mod3_val = lanes % LANE_W'(3);
   assign mul3_val = lanes - mod3_val;

   // fixed counts 1..8: value is the code itself, zero when above the lanes
   always_comb begin
      small_val = '0;
      if (pattern >= PAT_FIX_LO && pattern <= PAT_FIX_HI &&
          int'(pattern) <= int'(lanes))
         small_val = LANE_W'(pattern);
   end

   // fixed counts 16..256: one comparator per step
   for (genvar k = 0; k < BIG_STEPS; k++) begin : g_big
      localparam int STEP_CNT = BIG_BASE << k;
      localparam logic [PAT_W-1:0] STEP_CODE = PAT_BIG_LO + PAT_W'(k);
      assign big_part[k] = (pattern == STEP_CODE && int'(lanes) >= STEP_CNT)
                           ? LANE_W'(STEP_CNT) : '0;
   end

   always_comb begin
      big_val = '0;
      for (int k = 0; k < BIG_STEPS; k++) big_val = big_val | big_part[k];
   end

   always_comb begin
      case (pattern)
         PAT_POW2: count = pow2_val;
         PAT_MUL4: count = mul4_val;
         PAT_MUL3: count = mul3_val;
         PAT_ALL:  count = lanes;
         default:  count = small_val | big_val;
      endcase
   end

endmodule

// File: rtl/psd_sat_sub.sv
module psd_sat_sub #(
   parameter int DATA_W     = 64,
   parameter int NARROW_W   = 32,
   parameter int LANE_W     = 6,
   parameter int MULT_W     = 4,
   parameter bit HAS_NARROW = 1'b1
)(
   input  logic [DATA_W-1:0] operand,
   input  logic              narrow,
   input  logic [LANE_W-1:0] count,
   input  logic [MULT_W-1:0] mult_field,
   output logic [DATA_W-1:0] result,
   output logic              sat
);

   localparam int PROD_W = LANE_W + MULT_W + 1;
   localparam int EXT_W  = DATA_W + 2;

   localparam logic [EXT_W-1:0] WIDE_MIN =
      {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
   localparam logic [EXT_W-1:0] NARROW_MIN =
      {{(EXT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

   logic [MULT_W:0]    scale;
   logic [PROD_W-1:0]  prod;
   logic [EXT_W-1:0]   src_ext;
   logic [EXT_W-1:0]   limit;
   logic [EXT_W-1:0]   diff;

   assign scale = {1'b0, mult_field} + (MULT_W+1)'(1);
   assign prod  = PROD_W'(count) * PROD_W'(scale);

   if (HAS_NARROW) begin : g_dual
      logic [EXT_W-1:0] wide_ext;
      logic [EXT_W-1:0] narrow_ext;
      assign wide_ext   = {{(EXT_W-DATA_W){operand[DATA_W-1]}}, operand};
      assign narrow_ext = {{(EXT_W-NARROW_W){operand[NARROW_W-1]}},
                           operand[NARROW_W-1:0]};
      assign src_ext = narrow ? narrow_ext : wide_ext;
      assign limit   = narrow ? NARROW_MIN : WIDE_MIN;
   end else begin : g_wide_only
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign src_ext = {{(EXT_W-DATA_W){operand[DATA_W-1]}}, operand};
      assign limit   = WIDE_MIN;
   end

   assign diff   = src_ext - {{(EXT_W-PROD_W){1'b0}}, prod};
   assign sat    = $signed(diff) < $signed(limit);
   // inside the range the low DATA_W bits are already sign-extended
   assign result = sat ? limit[DATA_W-1:0] : diff[DATA_W-1:0];

endmodule

// File: rtl/pred_satdec.sv
module pred_satdec
   import psd_pkg::*;
#(
   parameter int VLEN_W   = 12,
   parameter int ESIZE    = 64,
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   parameter int MULT_W   = 4
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [4:0]        in_pattern,
   input  logic [3:0]        in_mult,
   input  logic              in_narrow,
   input  logic [63:0]       in_operand,
   input  logic [11:0]       cfg_vlen,
   output logic              out_valid,
   output logic [63:0]       out_result,
   output logic              out_sat
);

   localparam int LANE_SHIFT = $clog2(ESIZE);
   localparam int LANE_W     = VLEN_W - LANE_SHIFT;
   localparam logic [DATA_W-1:0] WIDE_MIN64 = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] NARROW_MIN64 =
      {{(DATA_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

   // elaboration-time parameter checks
   if (ESIZE != (1 << LANE_SHIFT)) begin : g_bad_esize
      $error("ESIZE must be a power of two");
   end
   if (LANE_W < 3) begin : g_bad_vlen
      $error("VLEN_W too small for the element size");
   end
   if (NARROW_W >= DATA_W) begin : g_bad_narrow
      $error("NARROW_W must be below DATA_W");
   end
   if (DATA_W != 64 || VLEN_W != 12 || MULT_W != 4) begin : g_bad_ports
      $error("port widths are fixed at 64/12/4");
   end

   logic [LANE_W-1:0] lanes;
   logic [LANE_W-1:0] dec_count;
   logic [DATA_W-1:0] sub_result;
   logic              sub_sat;

   assign lanes = cfg_vlen[VLEN_W-1:LANE_SHIFT];

   psd_count_decode #(.LANE_W(LANE_W)) u_decode (
      .pattern (in_pattern),
      .lanes   (lanes),
      .count   (dec_count)
   );

   psd_sat_sub #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W),
      .LANE_W   (LANE_W),
      .MULT_W   (MULT_W),
      .HAS_NARROW(1'b1)
   ) u_sub (
      .operand    (in_operand),
      .narrow     (in_narrow),
      .count      (dec_count),
      .mult_field (in_mult),
      .result     (sub_result),
      .sat        (sub_sat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_sat    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= sub_result;
            out_sat    <= sub_sat;
         end
      end
   end

   // ---------------- assertions ----------------
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_vlen_legal_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (cfg_vlen[LANE_SHIFT:0] == '0 && cfg_vlen != '0));

   p_count_le_lanes_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> dec_count <= lanes);

   p_never_above_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_narrow) |=>
         $signed(out_result) <= $signed($past(in_operand)));

   p_sat_value_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (!out_sat ||
         out_result == ($past(in_narrow) ? NARROW_MIN64 : WIDE_MIN64)));

   p_narrow_sext_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_narrow) |=>
         out_result[DATA_W-1:NARROW_W] == {(DATA_W-NARROW_W){out_result[NARROW_W-1]}});

   p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_result == '0 && !out_sat));

endmodule

// File: tb/sim_pred_satdec.sv
`timescale 1ns/1ps
module sim_pred_satdec;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [4:0]  in_pattern = '0;
   logic [3:0]  in_mult = '0;
   logic        in_narrow = 1'b0;
   logic [63:0] in_operand = '0;
   logic [11:0] cfg_vlen = 12'd128;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_sat;

   always #2 clk = ~clk;   // 250 MHz

   pred_satdec u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_pattern(in_pattern),
      .in_mult(in_mult), .in_narrow(in_narrow), .in_operand(in_operand),
      .cfg_vlen(cfg_vlen), .out_valid(out_valid), .out_result(out_result),
      .out_sat(out_sat)
   );

   typedef struct {
      logic [63:0] res;
      logic        sat;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   localparam longint MINL = 64'sh8000_0000_0000_0000;

   // ---------- behavioural reference ----------
   function automatic int ref_count(int pat, int lanes);
      int p;
      if (pat == 0) begin
         p = 1;
         while (p * 2 <= lanes) p = p * 2;
         return p;
      end
      if (pat >= 1 && pat <= 8) return (pat <= lanes) ? pat : 0;
      if (pat >= 9 && pat <= 13) begin
         p = 16 << (pat - 9);
         return (p <= lanes) ? p : 0;
      end
      if (pat == 29) return (lanes / 4) * 4;
      if (pat == 30) return (lanes / 3) * 3;
      if (pat == 31) return lanes;
      return 0;
   endfunction

   function automatic string tag_of(int pat, bit narrow);
      if (narrow) return "R8";
      if (pat == 0) return "R3";
      if (pat >= 1 && pat <= 13) return "R4";
      if (pat >= 29) return "R5";
      return "R6";
   endfunction

   task automatic send(input int pat, input int mult, input bit narrow,
                       input logic [63:0] op, input int vlen, input string tag);
      exp_t   e;
      longint prod;
      longint a;
      @(negedge clk);
      #1;
      in_valid   = 1'b1;
      in_pattern = 5'(pat);
      in_mult    = 4'(mult);
      in_narrow  = narrow;
      in_operand = op;
      cfg_vlen   = 12'(vlen);
      prod = longint'(ref_count(pat, vlen / 64)) * longint'(mult + 1);
      if (narrow) begin
         a = longint'($signed(op[31:0])) - prod;
         if (a < -64'sd2147483648) begin
            e.res = 64'hFFFF_FFFF_8000_0000; e.sat = 1'b1;
         end else begin
            e.res = 64'(a); e.sat = 1'b0;
         end
      end else begin
         a = $signed(op);
         if (a < MINL + prod) begin
            e.res = 64'h8000_0000_0000_0000; e.sat = 1'b1;
         end else begin
            e.res = 64'(a - prod); e.sat = 1'b0;
         end
      end
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      #1;
      in_valid   = 1'b0;
      in_pattern = 5'($urandom);
      in_operand = {$urandom, $urandom};
   endtask

   task automatic check_reset_state(input string tag);
      checks++;
      if (out_valid !== 1'b0 || out_result !== 64'h0 || out_sat !== 1'b0) begin
         fails++;
         $display("FAIL %s reset state: valid=%b result=%h sat=%b expected 0/0/0",
                  tag, out_valid, out_result, out_sat);
      end
   endtask

   // ---------- monitor: compare on every clock ----------
   always @(negedge clk) begin
      exp_t e;
      bit   exp_v;
      if (!rst && !done) begin
         exp_v = (q.size() != 0);
         checks++;
         if (out_valid !== exp_v) begin
            fails++;
            $display("FAIL R1 out_valid=%b expected %b", out_valid, exp_v);
         end
         if (exp_v) begin
            e = q.pop_front();
            checks++;
            if (out_result !== e.res || out_sat !== e.sat) begin
               fails++;
               $display("FAIL %s result=%h sat=%b expected result=%h sat=%b",
                        e.tag, out_result, out_sat, e.res, e.sat);
            end
         end
      end
   end

   // ---------- watchdog ----------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // ---------- stimulus ----------
   initial begin
      logic [63:0] op;
      repeat (3) @(negedge clk);
      check_reset_state("R10");
      #1 rst = 1'b0;

      // R3: power of two below lane count
      send(0, 0, 0, 64'd1000, 128,  "R3");   // 2 lanes -> 2
      send(0, 0, 0, 64'd1000, 384,  "R3");   // 6 -> 4
      send(0, 1, 0, 64'd1000, 1920, "R3");   // 30 -> 16, x2
      send(0, 0, 0, 64'd1000, 2048, "R3");   // 32
      idle();

      // R4: fixed counts, including ones above the lane count
      send(3, 0, 0, 64'd50, 128,  "R4");     // 3 > 2 lanes -> 0
      send(3, 0, 0, 64'd50, 256,  "R4");     // 3
      send(8, 0, 0, 64'd50, 512,  "R4");     // 8
      send(9, 0, 0, 64'd50, 2048, "R4");     // 16
      send(10, 0, 0, 64'd50, 2048, "R4");    // 32
      send(13, 0, 0, 64'd50, 2048, "R4");    // 256 > 32 -> 0
      send(9, 0, 0, 64'd50, 896,  "R4");     // 16 > 14 -> 0
      idle();
      idle();

      // R5
      send(29, 0, 0, 64'd100, 1920, "R5");   // 30 -> 28
      send(30, 0, 0, 64'd100, 2048, "R5");   // 32 -> 30
      send(31, 0, 0, 64'd100, 1408, "R5");   // 22
      send(30, 0, 0, 64'd100, 128,  "R5");   // 2 -> 0

      // R6: unused codes leave the operand intact
      send(14, 15, 0, 64'h0123_4567_89AB_CDEF, 2048, "R6");
      send(15, 15, 0, 64'h8000_0000_0000_0000, 2048, "R6");
      send(16, 3, 0, 64'd7, 2048, "R6");
      send(20, 3, 0, 64'd7, 2048, "R6");
      send(28, 3, 0, 64'd7, 2048, "R6");
      idle();

      // R2: multiplier extremes
      send(31, 15, 0, 64'd10000, 2048, "R2");   // 512
      send(31, 0, 0, 64'd10000, 2048, "R2");    // 32
      send(31, 15, 0, 64'd0, 2048, "R2");       // -512

      // R7 / R9: 64-bit boundary
      send(31, 15, 0, 64'h8000_0000_0000_0200, 2048, "R9");  // exactly min
      send(31, 15, 0, 64'h8000_0000_0000_01FF, 2048, "R7");  // one below
      send(31, 0, 0, 64'h8000_0000_0000_0005, 2048, "R7");
      send(31, 15, 0, 64'h7FFF_FFFF_FFFF_FFFF, 2048, "R9");
      idle();

      // R8: 32-bit mode
      send(1, 0, 1, 64'hDEAD_BEEF_0000_0010, 128, "R8");     // 16-1
      send(1, 0, 1, 64'h0000_0001_8000_0001, 128, "R8");     // -> min, no sat
      send(2, 0, 1, 64'h0000_0001_8000_0001, 128, "R8");     // sat
      send(1, 0, 1, 64'hFFFF_FFFF_7FFF_FFFF, 128, "R8");     // positive
      send(31, 15, 1, 64'h0000_0000_8000_0200, 2048, "R8");  // exactly min
      send(31, 15, 1, 64'h0000_0000_8000_01FF, 2048, "R8");  // sat
      idle();

      // R10: reset with valid input present
      send(31, 0, 0, 64'd99, 2048, "R1");
      idle();
      @(negedge clk);
      #1 rst = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      check_reset_state("R10");
      #1 rst = 1'b0; in_valid = 1'b0;
      idle();

      // mixed sweep
      for (int i = 0; i < 400; i++) begin
         op = {$urandom, $urandom};
         if (i % 4 == 0) op = 64'h8000_0000_0000_0000 + 64'($urandom % 600);
         if (i % 4 == 1) op = {$urandom, 32'h8000_0000 + 32'($urandom % 600)};
         begin
            int  pat = int'($urandom % 32);
            bit  nar = (i % 3 == 1);
            send(pat, int'($urandom % 16), nar, op,
                 128 * (1 + int'($urandom % 16)), tag_of(pat, nar));
         end
         if (i % 7 == 0) idle();
      end
      idle();
      idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule